// File: doc/BRIEF.md
# Two-Wide Register Rename Unit

This block renames two instructions per cycle, in program order, from fifteen architectural registers onto sixty-four physical registers. Each slot presents a valid bit, a write flag, two source register indices and a destination index. In the same cycle the unit returns the physical tags of both sources, a freshly allocated physical tag for the destination, and the physical tag the destination was mapped to before. The caller keeps that old tag and hands it back through the return port when the instruction retires.

The unit holds the architectural-to-physical map and a first-in first-out free list of physical tags. After reset, architectural register n maps to physical register n. The free pool holds physical registers 16 through 63, in ascending order; register 64 only enters the pool if it is returned. The two slots behave as if they were renamed one after the other. Slot 1 therefore sees the tag that slot 0 has just allocated. When the pool cannot cover every destination in the group, the group is held back as a whole.

Top module: `rn_rename2`

## Requirements
- R1: After reset, a source index n in 1..15 reads physical tag n, and index 0 (no register) reads tag 0.
- R2: The first tags allocated after reset are 16, 17, 18, ... in ascending order, and every allocated tag lies in 1..64.
- R3: In an accepted group, slot 0 takes the oldest free tag and slot 1 takes the next one. A slot that does not write takes no tag and reports a new tag of 0.
- R4: A source of slot 1 that names the register written by slot 0 in the same group gets slot 0's new tag.
- R5: If both slots write the same register, slot 1's old-tag output is slot 0's new tag, and afterwards the register maps to slot 1's new tag.
- R6: The old-tag output of a writing slot is the mapping the destination held before the group, including mappings made by earlier groups.
- R7: Returned tags join the free list at its tail, return lane 0 before lane 1, and are allocated after all tags already free.
- R8: When the number of writing slots exceeds the free tags, rn_stall is 1 in that cycle and neither the map nor the free list changes: a later group gets the same tags and sees the same mappings.
- R9: Returns are accepted in every cycle, also while stalled. A returned tag becomes available for allocation from the next cycle.
- R10: A slot with its write flag at 0, or with destination index 0, or that is not valid, allocates nothing and changes no mapping. A group with no such writes never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rn_valid | input | 2 | Slot valid bits, bit 0 is the older instruction |
| rn_wr | input | 2 | Slot has a destination register |
| rn_src_a | input | 2x4 | First source index per slot |
| rn_src_b | input | 2x4 | Second source index per slot |
| rn_dst | input | 2x4 | Destination index per slot |
| ret_valid | input | 2 | Return lane valid bits |
| ret_tag | input | 2x7 | Physical tags returned to the free list |
| rn_stall | output | 1 | Group cannot be renamed this cycle |
| ph_src_a | output | 2x7 | Physical tag of first source per slot |
| ph_src_b | output | 2x7 | Physical tag of second source per slot |
| ph_dst_new | output | 2x7 | Newly allocated tag per slot (0 if none) |
| ph_dst_old | output | 2x7 | Previous mapping of the destination per slot (0 if none) |

## Verification
All rename outputs and rn_stall are combinational and belong to the cycle in which the group is presented. The map and the free list update on the next rising edge, so the effect of a group or a return first shows in the following cycle's outputs. The bench drives each group just after a falling edge and compares the outputs 1 ns before the rising edge. It then advances its sequential reference map and free queue after that edge, so each check compares one cycle's outputs against the state left by the cycles before it.

// File: rtl/rn_pkg.sv
package rn_pkg;
   localparam int unsigned RN_SLOTS = 2;
   typedef logic [RN_SLOTS-1:0] rn_slot_mask_t;

   function automatic logic [1:0] rn_count2(input rn_slot_mask_t m);
      return {1'b0, m[0]} + {1'b0, m[1]};
   endfunction
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
   parameter int unsigned NUM_LOG = 15,
   parameter int unsigned LW      = 4,
   parameter int unsigned PW      = 7,
   parameter int unsigned NRD     = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NRD-1:0][LW-1:0]   rd_idx,
   output logic [NRD-1:0][PW-1:0]   rd_tag,
   input  logic [1:0]               we,
   input  logic [1:0][LW-1:0]       wr_idx,
   input  logic [1:0][PW-1:0]       wr_tag
);
   logic [PW-1:0] map_q [1:NUM_LOG];

   for (genvar r = 0; r < NRD; r++) begin : g_rd
      logic [PW-1:0] t;
      always_comb begin
         t = '0;
         for (int k = 1; k <= NUM_LOG; k++)
            if (rd_idx[r] == LW'(k)) t = map_q[k];
      end
      assign rd_tag[r] = t;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 1; k <= NUM_LOG; k++) map_q[k] <= PW'(k);
      end else begin
         for (int k = 1; k <= NUM_LOG; k++) begin
            if (we[1] && wr_idx[1] == LW'(k))      map_q[k] <= wr_tag[1];
            else if (we[0] && wr_idx[0] == LW'(k)) map_q[k] <= wr_tag[0];
         end
      end
   end
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
   parameter int unsigned PW      = 7,
   parameter int unsigned DEPTH   = 64,
   parameter int unsigned INIT_LO = 16,
   parameter int unsigned INIT_HI = 63,
   localparam int unsigned AW     = $clog2(DEPTH),
   localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           pop_n,
   input  logic [1:0]           push_v,
   input  logic [1:0][PW-1:0]   push_tag,
   output logic [1:0][PW-1:0]   head_tag,
   output logic [CW-1:0]        count
);
   localparam int unsigned INIT_N = INIT_HI - INIT_LO + 1;

   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rn_free_list: DEPTH must be a power of two");
   end
   if (INIT_N > DEPTH) begin : g_bad_init
      $error("rn_free_list: initial pool larger than DEPTH");
   end

   logic [PW-1:0] mem [DEPTH];
   logic [AW-1:0] rd_q, wr_q;
   logic [CW-1:0] cnt_q;

   assign head_tag[0] = mem[rd_q];
   assign head_tag[1] = mem[rd_q + AW'(1)];
   assign count       = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            mem[i] <= (i < INIT_N) ? PW'(INIT_LO + i) : '0;
         rd_q  <= '0;
         wr_q  <= AW'(INIT_N);
         cnt_q <= CW'(INIT_N);
      end else begin
         if (push_v[0]) mem[wr_q] <= push_tag[0];
         if (push_v[1]) mem[wr_q + AW'(push_v[0])] <= push_tag[1];
         rd_q  <= rd_q + AW'(pop_n);
         wr_q  <= wr_q + AW'(push_v[0]) + AW'(push_v[1]);
         cnt_q <= cnt_q + CW'(push_v[0]) + CW'(push_v[1]) - CW'(pop_n);
      end
   end
endmodule

// File: rtl/rn_slot_fwd.sv
module rn_slot_fwd #(
   parameter int unsigned LW = 4,
   parameter int unsigned PW = 7,
   parameter int unsigned NF = 3
) (
   input  logic                   prod_we,
   input  logic [LW-1:0]          prod_idx,
   input  logic [PW-1:0]          prod_tag,
   input  logic [NF-1:0][LW-1:0]  cons_idx,
   input  logic [NF-1:0][PW-1:0]  tbl_tag,
   output logic [NF-1:0][PW-1:0]  res_tag
);
   for (genvar f = 0; f < NF; f++) begin : g_fwd
      assign res_tag[f] = (prod_we && cons_idx[f] == prod_idx) ? prod_tag : tbl_tag[f];
   end
endmodule

// File: rtl/rn_rename2.sv
module rn_rename2
   import rn_pkg::*;
#(
   parameter int unsigned NUM_LOG  = 15,
   parameter int unsigned NUM_PHYS = 64,
   parameter int unsigned FREE_LO  = 16,
   parameter int unsigned FREE_HI  = 63,
   parameter int unsigned FL_DEPTH = 64,
   localparam int unsigned LW      = $clog2(NUM_LOG + 1),
   localparam int unsigned PW      = $clog2(NUM_PHYS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          rn_valid,
   input  logic [1:0]          rn_wr,
   input  logic [1:0][LW-1:0]  rn_src_a,
   input  logic [1:0][LW-1:0]  rn_src_b,
   input  logic [1:0][LW-1:0]  rn_dst,
   input  logic [1:0]          ret_valid,
   input  logic [1:0][PW-1:0]  ret_tag,
   output logic                rn_stall,
   output logic [1:0][PW-1:0]  ph_src_a,
   output logic [1:0][PW-1:0]  ph_src_b,
   output logic [1:0][PW-1:0]  ph_dst_new,
   output logic [1:0][PW-1:0]  ph_dst_old
);
   localparam int unsigned CW     = $clog2(FL_DEPTH + 1);
   localparam int unsigned FREE_N = FREE_HI - FREE_LO + 1;

   if (FREE_LO <= NUM_LOG || FREE_HI > NUM_PHYS || FREE_HI < FREE_LO) begin : g_bad_pool
      $error("rn_rename2: free pool range must lie above the reset mappings");
   end
   if (FL_DEPTH < NUM_PHYS - NUM_LOG) begin : g_bad_fl
      $error("rn_rename2: free list too shallow for all spare tags");
   end

   rn_slot_mask_t          wr_eff;
   logic [1:0]             need;
   logic [1:0]             pop_n;
   logic                   fire;
   logic [1:0][PW-1:0]     fl_head;
   logic [CW-1:0]          fl_count;
   logic [1:0][PW-1:0]     new_tag;
   logic [5:0][LW-1:0]     tbl_idx;
   logic [5:0][PW-1:0]     tbl_tag;
   logic [2:0][PW-1:0]     s1_res;

   for (genvar s = 0; s < 2; s++) begin : g_slot
      assign wr_eff[s] = rn_valid[s] & rn_wr[s] & (rn_dst[s] != '0);
      assign tbl_idx[3*s]   = rn_src_a[s];
      assign tbl_idx[3*s+1] = rn_src_b[s];
      assign tbl_idx[3*s+2] = rn_dst[s];
      assign ph_dst_new[s]  = wr_eff[s] ? new_tag[s] : '0;
   end

   assign need     = rn_count2(wr_eff);
   assign rn_stall = CW'(need) > fl_count;
   assign fire     = !rn_stall;
   assign pop_n    = fire ? need : 2'd0;

   assign new_tag[0] = fl_head[0];
   assign new_tag[1] = wr_eff[0] ? fl_head[1] : fl_head[0];

   rn_free_list #(
      .PW(PW), .DEPTH(FL_DEPTH), .INIT_LO(FREE_LO), .INIT_HI(FREE_HI)
   ) u_fl (
      .clk(clk), .rst_n(rst_n), .pop_n(pop_n),
      .push_v(ret_valid), .push_tag(ret_tag),
      .head_tag(fl_head), .count(fl_count)
   );

   rn_map_table #(
      .NUM_LOG(NUM_LOG), .LW(LW), .PW(PW), .NRD(6)
   ) u_map (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(tbl_idx), .rd_tag(tbl_tag),
      .we(wr_eff & {2{fire}}), .wr_idx(rn_dst), .wr_tag(new_tag)
   );

   rn_slot_fwd #(.LW(LW), .PW(PW), .NF(3)) u_fwd (
      .prod_we(wr_eff[0]), .prod_idx(rn_dst[0]), .prod_tag(new_tag[0]),
      .cons_idx(tbl_idx[5:3]), .tbl_tag(tbl_tag[5:3]), .res_tag(s1_res)
   );

   assign ph_src_a[0]   = tbl_tag[0];
   assign ph_src_b[0]   = tbl_tag[1];
   assign ph_dst_old[0] = wr_eff[0] ? tbl_tag[2] : '0;
   assign ph_src_a[1]   = s1_res[0];
   assign ph_src_b[1]   = s1_res[1];
   assign ph_dst_old[1] = wr_eff[1] ? s1_res[2] : '0;
endmodule

// File: rtl/rn_rename2_chk.sv
module rn_rename2_chk #(
   parameter int unsigned PW       = 7,
   parameter int unsigned CW       = 7,
   parameter int unsigned NUM_PHYS = 64,
   parameter int unsigned FL_DEPTH = 64,
   parameter int unsigned FREE_N   = 48
) (
   input logic               clk,
   input logic               rst_n,
   input logic [1:0]         wr_eff,
   input logic               rn_stall,
   input logic [1:0][PW-1:0] ph_dst_new,
   input logic [CW-1:0]      fl_count,
   input logic [1:0]         pop_n,
   input logic [1:0]         ret_valid
);
   AST_RESET_POOL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> fl_count == CW'(FREE_N)); // R2

   AST_TAG_RANGE0: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_eff[0] && !rn_stall) |-> (ph_dst_new[0] != '0 && ph_dst_new[0] <= PW'(NUM_PHYS))); // R2

   AST_TAG_RANGE1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_eff[1] && !rn_stall) |-> (ph_dst_new[1] != '0 && ph_dst_new[1] <= PW'(NUM_PHYS))); // R2

   AST_NEW_TAGS_DIFFER: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_eff == 2'b11 && !rn_stall) |-> ph_dst_new[0] != ph_dst_new[1]); // R3

   AST_STALL_HOLDS_POOL: assert property (@(posedge clk) disable iff (!rst_n)
      (rn_stall && ret_valid == 2'b00) |=> fl_count == $past(fl_count)); // R8

   AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_eff == 2'b00) |-> !rn_stall); // R10

   AST_COUNT_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (fl_count + CW'($past(pop_n))) ==
               ($past(fl_count) + CW'($countones($past(ret_valid))))); // R7

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(fl_count) + $countones(ret_valid) <= FL_DEPTH)); // R9
endmodule

bind rn_rename2 rn_rename2_chk #(
   .PW(PW), .CW(CW), .NUM_PHYS(NUM_PHYS), .FL_DEPTH(FL_DEPTH), .FREE_N(FREE_N)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_eff(wr_eff), .rn_stall(rn_stall),
   .ph_dst_new(ph_dst_new), .fl_count(fl_count), .pop_n(pop_n),
   .ret_valid(ret_valid)
);

// File: tb/rn_rename2_tb.sv
module rn_rename2_tb;
   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [1:0]      rn_valid = '0, rn_wr = '0, ret_valid = '0;
   logic [1:0][3:0] rn_src_a = '0, rn_src_b = '0, rn_dst = '0;
   logic [1:0][6:0] ret_tag = '0;
   logic            rn_stall;
   logic [1:0][6:0] ph_src_a, ph_src_b, ph_dst_new, ph_dst_old;

   int errors = 0;
   int checks = 0;
   int ref_map [16];
   int ref_free [$];

   always #2 clk = ~clk;

   rn_rename2 u_dut (
      .clk(clk), .rst_n(rst_n), .rn_valid(rn_valid), .rn_wr(rn_wr),
      .rn_src_a(rn_src_a), .rn_src_b(rn_src_b), .rn_dst(rn_dst),
      .ret_valid(ret_valid), .ret_tag(ret_tag), .rn_stall(rn_stall),
      .ph_src_a(ph_src_a), .ph_src_b(ph_src_b),
      .ph_dst_new(ph_dst_new), .ph_dst_old(ph_dst_old)
   );

   task automatic chk(input string req, input string what, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
      end
   endtask

   // One group: predict from reference state, drive, compare, then advance the model.
   task automatic group(input string req,
                        input logic v0, input logic w0, input int a0, input int b0, input int d0,
                        input logic v1, input logic w1, input int a1, input int b1, input int d1,
                        input logic [1:0] rv, input int rt0, input int rt1);
      int tmp [16];
      bit e0, e1, stall;
      int n0, n1, idx;
      e0 = v0 && w0 && d0 != 0;
      e1 = v1 && w1 && d1 != 0;
      stall = (int'(e0) + int'(e1)) > ref_free.size();
      tmp = ref_map;
      idx = 0; n0 = 0; n1 = 0;
      if (!stall) begin
         if (e0) begin n0 = ref_free[0]; idx = 1; end
         if (e1) n1 = ref_free[idx];
         if (e0) tmp[d0] = n0;
      end
      rn_valid = {v1, v0}; rn_wr = {w1, w0};
      rn_src_a[0] = 4'(a0); rn_src_b[0] = 4'(b0); rn_dst[0] = 4'(d0);
      rn_src_a[1] = 4'(a1); rn_src_b[1] = 4'(b1); rn_dst[1] = 4'(d1);
      ret_valid = rv; ret_tag[0] = 7'(rt0); ret_tag[1] = 7'(rt1);
      #1;
      chk(req, "stall", int'(rn_stall), int'(stall));
      if (!stall) begin
         chk(req, "s0 src_a", int'(ph_src_a[0]), ref_map[a0]);
         chk(req, "s0 src_b", int'(ph_src_b[0]), ref_map[b0]);
         chk(req, "s1 src_a", int'(ph_src_a[1]), tmp[a1]);
         chk(req, "s1 src_b", int'(ph_src_b[1]), tmp[b1]);
         if (e0) begin
            chk(req, "s0 new", int'(ph_dst_new[0]), n0);
            chk(req, "s0 old", int'(ph_dst_old[0]), ref_map[d0]);
         end else chk(req, "s0 new none", int'(ph_dst_new[0]), 0);
         if (e1) begin
            chk(req, "s1 new", int'(ph_dst_new[1]), n1);
            chk(req, "s1 old", int'(ph_dst_old[1]), tmp[d1]);
         end else chk(req, "s1 new none", int'(ph_dst_new[1]), 0);
      end
      @(posedge clk);
      if (!stall) begin
         if (e0) void'(ref_free.pop_front());
         if (e1) begin void'(ref_free.pop_front()); tmp[d1] = n1; end
         ref_map = tmp;
      end
      if (rv[0]) ref_free.push_back(rt0);
      if (rv[1]) ref_free.push_back(rt1);
      @(negedge clk);
      rn_valid = '0; rn_wr = '0; ret_valid = '0;
   endtask

   task automatic t_reset;
      for (int k = 0; k < 4; k++)
         group("R1", 1'b0, 1'b0, 4*k, 4*k+1, 0, 1'b0, 1'b0, 4*k+2, 4*k+3, 0, 2'b00, 0, 0);
   endtask

   task automatic t_basic;
      // R2 / R3: first two tags are 16 and 17, slot 0 oldest
      group("R2", 1'b1, 1'b1, 1, 2, 3, 1'b1, 1'b1, 4, 5, 6, 2'b00, 0, 0);
      chk("R2", "pool after two", ref_free[0], 18);
   endtask

   task automatic t_bypass;
      group("R4", 1'b1, 1'b1, 1, 2, 7, 1'b1, 1'b1, 7, 7, 9, 2'b00, 0, 0);
   endtask

   task automatic t_same_dst;
      group("R5", 1'b1, 1'b1, 10, 1, 10, 1'b1, 1'b1, 10, 2, 10, 2'b00, 0, 0);
      group("R5", 1'b1, 1'b0, 10, 10, 0, 1'b0, 1'b0, 0, 0, 0, 2'b00, 0, 0);
   endtask

   task automatic t_old;
      group("R6", 1'b1, 1'b1, 3, 6, 3, 1'b1, 1'b1, 9, 3, 6, 2'b00, 0, 0);
   endtask

   task automatic t_single;
      group("R3", 1'b0, 1'b1, 1, 1, 5, 1'b1, 1'b1, 5, 2, 11, 2'b00, 0, 0);
      group("R3", 1'b1, 1'b0, 11, 2, 4, 1'b1, 1'b1, 11, 4, 4, 2'b00, 0, 0);
   endtask

   task automatic t_nowrite;
      group("R10", 1'b1, 1'b1, 1, 2, 0, 1'b1, 1'b0, 4, 5, 8, 2'b00, 0, 0);
      group("R10", 1'b1, 1'b1, 8, 4, 8, 1'b0, 1'b0, 0, 0, 0, 2'b00, 0, 0);
   endtask

   task automatic t_drain_stall;
      while (ref_free.size() >= 2)
         group("R8", 1'b1, 1'b1, 12, 13, 12, 1'b1, 1'b1, 12, 13, 13, 2'b00, 0, 0);
      if (ref_free.size() == 1) begin
         group("R8", 1'b1, 1'b1, 12, 13, 14, 1'b1, 1'b1, 1, 2, 15, 2'b00, 0, 0);
         chk("R8", "map unchanged r14", ref_map[14], 14);
         group("R8", 1'b1, 1'b1, 14, 15, 14, 1'b0, 1'b0, 0, 0, 0, 2'b00, 0, 0);
      end
      chk("R8", "pool empty", ref_free.size(), 0);
      group("R8", 1'b0, 1'b0, 1, 1, 0, 1'b1, 1'b1, 2, 2, 15, 2'b00, 0, 0);
      group("R8", 1'b1, 1'b0, 15, 15, 0, 1'b0, 1'b0, 0, 0, 0, 2'b00, 0, 0);
   endtask

   task automatic t_return;
      // R9: returns while stalled are taken but not usable in that cycle
      group("R9", 1'b1, 1'b1, 1, 2, 1, 1'b0, 1'b0, 0, 0, 0, 2'b11, 3, 6);
      // R7: returned tags come out in lane order
      group("R7", 1'b1, 1'b1, 1, 2, 1, 1'b1, 1'b1, 1, 1, 2, 2'b00, 0, 0);
      chk("R7", "r2 mapped to second return", ref_map[2], 6);
      group("R7", 1'b0, 1'b0, 0, 0, 0, 1'b0, 1'b0, 0, 0, 0, 2'b10, 0, 64);
      group("R7", 1'b0, 1'b0, 0, 0, 0, 1'b0, 1'b0, 0, 0, 0, 2'b01, 7, 0);
      group("R7", 1'b1, 1'b1, 2, 1, 5, 1'b1, 1'b1, 5, 5, 8, 2'b00, 0, 0);
      group("R7", 1'b1, 1'b0, 5, 8, 0, 1'b1, 1'b0, 1, 2, 0, 2'b00, 0, 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      ref_map[0] = 0;
      for (int n = 1; n < 16; n++) ref_map[n] = n;
      for (int t = 16; t <= 63; t++) ref_free.push_back(t);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_bypass();
      t_same_dst();
      t_old();
      t_single();
      t_nowrite();
      t_drain_stall();
      t_return();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule